// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This unit keeps the timekeeping state of a processor core. It holds two free-running 64-bit up counters: a main time base and an alternate time base. It also holds two 32-bit down counters: the decrementer and the hypervisor decrementer. A 64-bit utilisation counter sits alongside them. Every counter advances on a shared one-cycle tick enable that comes from the time-base clock. Software reaches each 32-bit half through a select-addressed write port and a combinational read port.

Each decrementer raises its own exception request in two cases. The first is when it counts down past zero, at which point it reloads to all ones. The second is when software stores a negative value over a non-negative one. Both requests stay asserted until acknowledged. A level enable input freezes and resumes both time bases together. A setup strobe puts the decrementers and the utilisation counter into their initial state.

Top module: `timebase_unit`

## Requirements
- R1: Out of reset both time bases and the utilisation counter read 0. While `runEn` is high, each cycle with `tickEn` high adds one to both time bases, and the carry passes from the low word into the high word.
- R2: A write to select 0 replaces only the low word of the main time base, and a write to select 1 replaces only its high word. The other half keeps its value. A written half takes the written value in that cycle, and no tick is added in that cycle.
- R3: While `runEn` is low, both time bases hold their values whatever `tickEn` does. When `runEn` returns high they count on from the held values. Lowering an already low enable, or raising an already high one, changes nothing.
- R4: The alternate time base has the low word at select 2 and the high word at select 3. It behaves as R1 to R3 describe, and its writes do not touch the main time base.
- R5: The decrementer is at select 4 and reads 0xFFFFFFFF after reset. It decreases by one on every `tickEn`, whatever `runEn` is. A tick while it holds 0 loads 0xFFFFFFFF and sets `decIrq`.
- R6: A software write to the decrementer sets `decIrq` only when bit 31 of the new value is 1 and bit 31 of the old value is 0.
- R7: The hypervisor decrementer is at select 5 and follows the rules of R5 and R6. It drives its own request, `hdecIrq`, and never sets `decIrq`.
- R8: A pulse on `setupStb` loads both decrementers with 0xFFFFFFFF and clears the utilisation counter. It raises neither request and leaves both time bases unchanged.
- R9: The utilisation counter has the low word at select 6 and the high word at select 7. It reads the last value written plus one for every `tickEn` since that write, whatever `runEn` is. Half writes work as in R2.
- R10: `decIrq` and `hdecIrq` stay high until their acknowledge input is high at a clock edge. A new request in the same cycle as an acknowledge wins.
- R11: Select 8 reads the main low word ANDed with 0x3FFFFF80. A write to select 8 stores the written data ANDed with 0x3FFFFF80 into the main low word and leaves the high word unchanged. Select 9 reads and writes the main high word.
- R12: Selects 10 to 15 read 0. Writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle tick from the time-base clock |
| runEn | input | 1 | High lets the time bases count; low freezes them |
| setupStb | input | 1 | Setup pulse: decrementers to all ones, utilisation counter to 0 |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 4 | Write select |
| wrData | input | 32 | Write data |
| rdSel | input | 4 | Read select |
| rdData | output | 32 | Read data (combinational) |
| decAck | input | 1 | Clears `decIrq` |
| hdecAck | input | 1 | Clears `hdecIrq` |
| decIrq | output | 1 | Sticky decrementer exception request |
| hdecIrq | output | 1 | Sticky hypervisor decrementer exception request |

## Verification
The assertions check these rules on every cycle:
- Expiry of either decrementer reloads all ones and raises its request.
- A negative-over-non-negative store raises the decrementer request.
- Requests stay set until acknowledged.
- The time bases stay still while frozen.
- A setup pulse loads the counters without raising a request.

Only the bench scenarios can show the following:
- Half-word isolation and the carry between words.
- Resuming from the held value after a freeze.
- The masked legacy view.
- The unmapped selects.
- The difference between a store over a negative value and one over a non-negative value.
- The precedence of a new request over a same-cycle acknowledge.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_TB_LO   = 4'd0,
    SEL_TB_HI   = 4'd1,
    SEL_ATB_LO  = 4'd2,
    SEL_ATB_HI  = 4'd3,
    SEL_DEC     = 4'd4,
    SEL_HDEC    = 4'd5,
    SEL_UTIL_LO = 4'd6,
    SEL_UTIL_HI = 4'd7,
    SEL_RTC_LO  = 4'd8,
    SEL_RTC_HI  = 4'd9
  } regSel_e;

  // Strobes from control to datapath; index 0 = low half, 1 = high half
  typedef struct packed {
    logic       tbTick;
    logic       anyTick;
    logic       setup;
    logic [1:0] wrTb;
    logic [1:0] wrAtb;
    logic [1:0] wrUtil;
    logic       wrDec;
    logic       wrHdec;
    logic       rtcMask;
  } strobes_t;
endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
(
  input  logic             tickEn,
  input  logic             runEn,
  input  logic             setupStb,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output strobes_t         stb
);
  always_comb begin
    stb         = '0;
    stb.anyTick = tickEn;
    stb.tbTick  = tickEn & runEn;
    stb.setup   = setupStb;
    if (wrEn) begin
      case (regSel_e'(wrSel))
        SEL_TB_LO:   stb.wrTb[0]   = 1'b1;
        SEL_TB_HI:   stb.wrTb[1]   = 1'b1;
        SEL_ATB_LO:  stb.wrAtb[0]  = 1'b1;
        SEL_ATB_HI:  stb.wrAtb[1]  = 1'b1;
        SEL_DEC:     stb.wrDec     = 1'b1;
        SEL_HDEC:    stb.wrHdec    = 1'b1;
        SEL_UTIL_LO: stb.wrUtil[0] = 1'b1;
        SEL_UTIL_HI: stb.wrUtil[1] = 1'b1;
        SEL_RTC_LO: begin
          stb.wrTb[0] = 1'b1;
          stb.rtcMask = 1'b1;
        end
        SEL_RTC_HI:  stb.wrTb[1]   = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/timebase_decr.sv
module timebase_decr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          setup,
  input  logic          load,
  input  logic [DW-1:0] loadVal,
  input  logic          ack,
  output logic [DW-1:0] count,
  output logic          irq
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic raise;

  always_comb begin
    if (setup)     raise = 1'b0;
    else if (load) raise = loadVal[DW-1] && !count[DW-1];
    else           raise = tick && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= ALL_ONES;
      irq   <= 1'b0;
    end else begin
      if (setup)     count <= ALL_ONES;
      else if (load) count <= loadVal;
      else if (tick) count <= (count == '0) ? ALL_ONES : count - DW'(1);
      if (raise)     irq <= 1'b1;
      else if (ack)  irq <= 1'b0;
    end
  end
endmodule

// File: rtl/timebase_datapath.sv
module timebase_datapath
  import timebase_pkg::*;
#(
  parameter int              DW       = 32,
  parameter logic [DW-1:0]   RTC_MASK = 32'h3FFFFF80
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic [DW-1:0]   wrData,
  input  logic            decAck,
  input  logic            hdecAck,
  output logic [2*DW-1:0] tbVal,
  output logic [2*DW-1:0] atbVal,
  output logic [2*DW-1:0] utilVal,
  output logic [DW-1:0]   decVal,
  output logic [DW-1:0]   hdecVal,
  output logic            decIrq,
  output logic            hdecIrq
);
  localparam int TW    = 2 * DW;
  localparam int N_DEC = 2;

  function automatic logic [TW-1:0] stepUp(input logic [TW-1:0] cur,
                                           input logic [1:0]    wr,
                                           input logic [DW-1:0] d,
                                           input logic          tick);
    if (wr[0]) return {cur[TW-1:DW], d};
    if (wr[1]) return {d, cur[DW-1:0]};
    if (tick)  return cur + TW'(1);
    return cur;
  endfunction

  logic [DW-1:0] tbLoData;
  assign tbLoData = stb.rtcMask ? (wrData & RTC_MASK) : wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbVal   <= '0;
      atbVal  <= '0;
      utilVal <= '0;
    end else begin
      tbVal  <= stepUp(tbVal, stb.wrTb, stb.wrTb[0] ? tbLoData : wrData, stb.tbTick);
      atbVal <= stepUp(atbVal, stb.wrAtb, wrData, stb.tbTick);
      if (stb.setup) utilVal <= '0;
      else           utilVal <= stepUp(utilVal, stb.wrUtil, wrData, stb.anyTick);
    end
  end

  logic [N_DEC-1:0] decLoad;
  logic [N_DEC-1:0] decAckV;
  logic [N_DEC-1:0] decIrqV;
  logic [DW-1:0]    decCnt [N_DEC];

  assign decLoad = {stb.wrHdec, stb.wrDec};
  assign decAckV = {hdecAck, decAck};

  for (genvar i = 0; i < N_DEC; i++) begin : g_dec
    timebase_decr #(.DW(DW)) u_decr (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (stb.anyTick),
      .setup   (stb.setup),
      .load    (decLoad[i]),
      .loadVal (wrData),
      .ack     (decAckV[i]),
      .count   (decCnt[i]),
      .irq     (decIrqV[i])
    );
  end

  assign decVal  = decCnt[0];
  assign hdecVal = decCnt[1];
  assign decIrq  = decIrqV[0];
  assign hdecIrq = decIrqV[1];
endmodule

// File: rtl/timebase_unit.sv
module timebase_unit
  import timebase_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] RTC_MASK = 32'h3FFFFF80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             runEn,
  input  logic             setupStb,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [DW-1:0]    wrData,
  input  logic [SEL_W-1:0] rdSel,
  output logic [DW-1:0]    rdData,
  input  logic             decAck,
  input  logic             hdecAck,
  output logic             decIrq,
  output logic             hdecIrq
);
  localparam int TW = 2 * DW;

  strobes_t      stb;
  logic [TW-1:0] tbVal, atbVal, utilVal;
  logic [DW-1:0] decVal, hdecVal;

  timebase_ctrl u_ctrl (
    .tickEn   (tickEn),
    .runEn    (runEn),
    .setupStb (setupStb),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .stb      (stb)
  );

  timebase_datapath #(.DW(DW), .RTC_MASK(RTC_MASK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .decAck  (decAck),
    .hdecAck (hdecAck),
    .tbVal   (tbVal),
    .atbVal  (atbVal),
    .utilVal (utilVal),
    .decVal  (decVal),
    .hdecVal (hdecVal),
    .decIrq  (decIrq),
    .hdecIrq (hdecIrq)
  );

  always_comb begin
    case (regSel_e'(rdSel))
      SEL_TB_LO:   rdData = tbVal[DW-1:0];
      SEL_TB_HI:   rdData = tbVal[TW-1:DW];
      SEL_ATB_LO:  rdData = atbVal[DW-1:0];
      SEL_ATB_HI:  rdData = atbVal[TW-1:DW];
      SEL_DEC:     rdData = decVal;
      SEL_HDEC:    rdData = hdecVal;
      SEL_UTIL_LO: rdData = utilVal[DW-1:0];
      SEL_UTIL_HI: rdData = utilVal[TW-1:DW];
      SEL_RTC_LO:  rdData = tbVal[DW-1:0] & RTC_MASK;
      SEL_RTC_HI:  rdData = tbVal[TW-1:DW];
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/timebase_unit_chk.sv
module timebase_unit_chk
  import timebase_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             runEn,
  input logic             setupStb,
  input logic             wrEn,
  input logic [SEL_W-1:0] wrSel,
  input logic [DW-1:0]    wrData,
  input logic             decAck,
  input logic             decIrq,
  input logic             hdecIrq,
  input logic [DW-1:0]    decVal,
  input logic [DW-1:0]    hdecVal,
  input logic [2*DW-1:0]  tbVal,
  input logic [2*DW-1:0]  atbVal,
  input logic [2*DW-1:0]  utilVal
);
  logic decWr, hdecWr, tbWr, atbWr;
  assign decWr  = wrEn && (regSel_e'(wrSel) == SEL_DEC);
  assign hdecWr = wrEn && (regSel_e'(wrSel) == SEL_HDEC);
  assign tbWr   = wrEn && (regSel_e'(wrSel) inside {SEL_TB_LO, SEL_TB_HI, SEL_RTC_LO, SEL_RTC_HI});
  assign atbWr  = wrEn && (regSel_e'(wrSel) inside {SEL_ATB_LO, SEL_ATB_HI});

  a_r5_dec_expiry: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !setupStb && !decWr && decVal == '0 |=> decIrq && decVal == '1);

  a_r7_hdec_expiry: assert property (@(posedge clk) disable iff (!rstN)
    tickEn && !setupStb && !hdecWr && hdecVal == '0 |=> hdecIrq && hdecVal == '1);

  a_r6_store_raise: assert property (@(posedge clk) disable iff (!rstN)
    decWr && !setupStb && wrData[DW-1] && !decVal[DW-1] |=> decIrq);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    decIrq && !decAck |=> decIrq);

  a_r3_tb_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && !tbWr |=> $stable(tbVal));

  a_r3_atb_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && !atbWr |=> $stable(atbVal));

  a_r8_setup_load: assert property (@(posedge clk) disable iff (!rstN)
    setupStb |=> decVal == '1 && hdecVal == '1 && utilVal == '0);

  a_r8_setup_quiet: assert property (@(posedge clk) disable iff (!rstN)
    setupStb && !decIrq |=> !decIrq);
endmodule

bind timebase_unit timebase_unit_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .runEn    (runEn),
  .setupStb (setupStb),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .decAck   (decAck),
  .decIrq   (decIrq),
  .hdecIrq  (hdecIrq),
  .decVal   (decVal),
  .hdecVal  (hdecVal),
  .tbVal    (tbVal),
  .atbVal   (atbVal),
  .utilVal  (utilVal)
);

// File: tb/tb_timebase_unit.sv
module tb_timebase_unit;
  import timebase_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, runEn = 1'b0, setupStb = 1'b0, wrEn = 1'b0;
  logic [3:0]  wrSel = '0, rdSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        decAck = 1'b0, hdecAck = 1'b0, decIrq, hdecIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  timebase_unit dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runEn(runEn), .setupStb(setupStb),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .decAck(decAck), .hdecAck(hdecAck), .decIrq(decIrq), .hdecIrq(hdecIrq)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  sel;
    logic [31:0] data;
    logic [3:0]  rSel;
    logic [31:0] exp;
  } vec_t;

  // write, then read back; tick idle, time bases frozen
  localparam vec_t VEC [14] = '{
    '{8'd1,  4'd0,  32'h12345678, 4'd0,  32'h12345678}, // R1
    '{8'd2,  4'd1,  32'hCAFEF00D, 4'd0,  32'h12345678}, // R2 low kept
    '{8'd2,  4'd0,  32'h0BADBEEF, 4'd1,  32'hCAFEF00D}, // R2 high kept
    '{8'd4,  4'd2,  32'hA5A5A5A5, 4'd2,  32'hA5A5A5A5}, // R4
    '{8'd4,  4'd3,  32'h5A5A5A5A, 4'd2,  32'hA5A5A5A5}, // R4
    '{8'd4,  4'd2,  32'h00000042, 4'd0,  32'h0BADBEEF}, // R4 main untouched
    '{8'd11, 4'd8,  32'hFFFFFFFF, 4'd0,  32'h3FFFFF80}, // R11 masked store
    '{8'd11, 4'd9,  32'h00000007, 4'd1,  32'h00000007}, // R11
    '{8'd11, 4'd0,  32'h12345678, 4'd8,  32'h12345600}, // R11 masked view
    '{8'd9,  4'd6,  32'h00000010, 4'd6,  32'h00000010}, // R9
    '{8'd9,  4'd7,  32'h00000003, 4'd6,  32'h00000010}, // R9
    '{8'd12, 4'd15, 32'hDEADBEEF, 4'd15, 32'h00000000}, // R12
    '{8'd12, 4'd10, 32'hDEADBEEF, 4'd0,  32'h12345678}, // R12
    '{8'd6,  4'd4,  32'h00000100, 4'd4,  32'h00000100}  // R6 store, no raise
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    rdSel = s;
    #1;
    v = rdData;
  endtask

  task automatic rdChk(input string req, input logic [3:0] s, input logic [31:0] exp);
    logic [31:0] v;
    rd(s, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic pulseDecAck();
    @(negedge clk); decAck = 1'b1;
    @(negedge clk); decAck = 1'b0;
  endtask

  task automatic pulseHdecAck();
    @(negedge clk); hdecAck = 1'b1;
    @(negedge clk); hdecAck = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    rdChk("R1", 4'd0, 32'h0);
    rdChk("R9", 4'd6, 32'h0);
    rdChk("R5", 4'd4, 32'hFFFFFFFF);
    chk("R10", {31'b0, decIrq}, 32'h0);
    chk("R7", {31'b0, hdecIrq}, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i].sel, VEC[i].data);
      rdChk($sformatf("R%0d", VEC[i].req), VEC[i].rSel, VEC[i].exp);
    end
    chk("R6", {31'b0, decIrq}, 32'h0);

    // R1 carry across the halves, with R5 and R9 counting alongside
    wr(4'd0, 32'hFFFFFFFE);
    wr(4'd1, 32'h0);
    runEn = 1'b1;
    ticks(3);
    rdChk("R1", 4'd0, 32'h1);
    rdChk("R1", 4'd1, 32'h1);
    rdChk("R5", 4'd4, 32'hFD);
    rdChk("R9", 4'd6, 32'h13);
    rdChk("R4", 4'd2, 32'h45);

    // R3 freeze, then resume
    runEn = 1'b0;
    ticks(4);
    rdChk("R3", 4'd0, 32'h1);
    rdChk("R3", 4'd2, 32'h45);
    rdChk("R5", 4'd4, 32'hF9);
    rdChk("R9", 4'd6, 32'h17);
    runEn = 1'b1;
    ticks(2);
    rdChk("R3", 4'd0, 32'h3);
    rdChk("R3", 4'd2, 32'h47);
    runEn = 1'b0;

    // R5 expiry
    wr(4'd4, 32'h2);
    ticks(2);
    rdChk("R5", 4'd4, 32'h0);
    chk("R5", {31'b0, decIrq}, 32'h0);
    ticks(1);
    rdChk("R5", 4'd4, 32'hFFFFFFFF);
    chk("R5", {31'b0, decIrq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R10", {31'b0, decIrq}, 32'h1);
    pulseDecAck();
    chk("R10", {31'b0, decIrq}, 32'h0);

    // R6 store rules
    wr(4'd4, 32'h80000000);
    chk("R6", {31'b0, decIrq}, 32'h0);
    wr(4'd4, 32'h5);
    chk("R6", {31'b0, decIrq}, 32'h0);
    wr(4'd4, 32'h90000000);
    chk("R6", {31'b0, decIrq}, 32'h1);
    chk("R7", {31'b0, hdecIrq}, 32'h0);
    pulseDecAck();

    // R10 a new request beats a same-cycle acknowledge
    wr(4'd4, 32'h5);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 4'd4; wrData = 32'h80000000; decAck = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; decAck = 1'b0;
    chk("R10", {31'b0, decIrq}, 32'h1);
    pulseDecAck();

    // R7 hypervisor decrementer
    wr(4'd5, 32'h1);
    ticks(1);
    rdChk("R7", 4'd5, 32'h0);
    chk("R7", {31'b0, hdecIrq}, 32'h0);
    ticks(1);
    rdChk("R7", 4'd5, 32'hFFFFFFFF);
    chk("R7", {31'b0, hdecIrq}, 32'h1);
    chk("R7", {31'b0, decIrq}, 32'h0);
    pulseHdecAck();
    wr(4'd5, 32'h3);
    chk("R7", {31'b0, hdecIrq}, 32'h0);
    wr(4'd5, 32'h80000000);
    chk("R7", {31'b0, hdecIrq}, 32'h1);
    pulseHdecAck();

    // R8 setup
    wr(4'd4, 32'h10);
    wr(4'd5, 32'h20);
    wr(4'd6, 32'h55);
    @(negedge clk); setupStb = 1'b1;
    @(negedge clk); setupStb = 1'b0;
    rdChk("R8", 4'd4, 32'hFFFFFFFF);
    rdChk("R8", 4'd5, 32'hFFFFFFFF);
    rdChk("R8", 4'd6, 32'h0);
    rdChk("R8", 4'd7, 32'h0);
    rdChk("R8", 4'd0, 32'h3);
    chk("R8", {30'b0, hdecIrq, decIrq}, 32'h0);

    // R9 counting from the cleared value while frozen
    ticks(4);
    rdChk("R9", 4'd6, 32'h4);
    rdChk("R3", 4'd0, 32'h3);

    finishRun();
  end
endmodule